// File: doc/BRIEF.md
# Latency-Slotted Writeback Scheduler

This block sits between the issue stage and the register file of a microcode engine whose pipeline is fully exposed to the program. Every instruction that produces a value hands that value over when it issues, together with its opcode. The block files the value into a small ring of slots. The slot is chosen so that the value comes out a fixed number of issues later, and that number is the opcode's latency. Nothing tracks the producer's own destination. The value that reaches the head of the ring is written to whatever destination the instruction issuing in that cycle names. The microcode compiler must therefore place each consumer's destination on the instruction that issues exactly one latency after the producer.

Only the issues that advance the queue count toward latency. The vector-output opcode is the exception. It leaves the ring untouched, does not step the program counter, and writes nothing. When a new value lands in a slot that still holds an undelivered value, the newer value wins and a saturating collision counter records the event. The arithmetic units themselves are outside this block.

Top module: `lat_wb_sched`

## Requirements
- R1: While reset is low, and after it is released, every slot holds zero, the head is at slot 0, the collision count is 0, and no write is signalled. This holds even if values were queued before reset.
- R2: A value issued with latency L is presented on `wr_data_o` during the L-th advancing issue after its own. It goes to the destination of that later issue, with `wr_en_o` high when that destination is nonzero.
- R3: Latency comes from the opcode encoding: 1 and 2 take 5, 3 takes 7, 6 takes 3, 8 and 9 take 4, and every other opcode from 10 through 15, as well as 4 and 5, takes 2.
- R4: `wr_en_o` is low whenever `issue_i` is low or `dest_i` is 0. A zero destination still advances the ring and discards the head value.
- R5: Opcode 0 (no-operation) advances the ring but inserts nothing. Its `result_i` never appears on any later write.
- R6: Opcode 7 (vector output) does not advance the ring, writes nothing, and keeps `step_o` low. Every other issued opcode raises `step_o`.
- R7: Slot indices wrap modulo 7, so arbitrary long mixes of opcodes, destinations, idle cycles and vector outputs keep the latency relation of R2.
- R8: When an inserted value targets a slot that still holds an undelivered value, the later value replaces it and `coll_cnt_o` rises by one on the next clock edge. The count saturates at its maximum.
- R9: Reading the head slot clears it, so a delivered value is never delivered a second time.
- R10: When `wr_en_o` is high, `wr_addr_o` equals the `dest_i` of the issue in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction issues this cycle |
| opcode_i | input | 4 | Opcode of the issuing instruction |
| dest_i | input | 7 | Destination register of the issuing instruction, 0 means none |
| result_i | input | 32 | Value produced by the issuing instruction |
| wr_en_o | output | 1 | Register-file write enable |
| wr_addr_o | output | 7 | Register-file write address |
| wr_data_o | output | 32 | Register-file write data (head slot) |
| step_o | output | 1 | Program counter advances this cycle |
| coll_cnt_o | output | 16 | Saturating count of slot collisions |

## Verification
Three kinds of stimulus are used. Directed single-producer sequences, one per opcode, separate the latency classes, because each class delivers its marker value on a different later issue. No-operation and vector-output filler is interleaved to show which issues count and which do not. Back-to-back producers with staggered latencies force overwrites, and long runs of empty issues after them show that delivered slots are cleared. A long pseudo-random sweep mixes all opcodes, zero destinations and idle cycles, and is checked against a delay-line model kept in the bench. That sweep exposes any off-by-one in the ring wrap.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_ADD    = 4'd1,
    OP_SUB    = 4'd2,
    OP_MUL    = 4'd3,
    OP_ABS    = 4'd4,
    OP_FTOI   = 4'd5,
    OP_ITOF   = 4'd6,
    OP_VOUT   = 4'd7,
    OP_SINE   = 4'd8,
    OP_COSINE = 4'd9
  } op_e;

  localparam int LAT_ADDSUB = 5;
  localparam int LAT_MUL    = 7;
  localparam int LAT_ITOF   = 3;
  localparam int LAT_TRIG   = 4;
  localparam int LAT_SHORT  = 2;
  localparam int MAX_LAT    = 7;
endpackage

// File: rtl/wbs_lat_lut.sv
module wbs_lat_lut
  import wbs_pkg::*;
#(
  parameter int OP_W  = 4,
  parameter int LAT_W = 3
) (
  input  logic [OP_W-1:0]  op_i,
  output logic [LAT_W-1:0] lat_o,
  output logic             ins_o,
  output logic             adv_o
);
  always_comb begin
    ins_o = 1'b1;
    adv_o = 1'b1;
    unique case (op_i)
      OP_NOP:          begin lat_o = '0; ins_o = 1'b0; end
      OP_VOUT:         begin lat_o = '0; ins_o = 1'b0; adv_o = 1'b0; end
      OP_ADD, OP_SUB:  lat_o = LAT_W'(LAT_ADDSUB);
      OP_MUL:          lat_o = LAT_W'(LAT_MUL);
      OP_ITOF:         lat_o = LAT_W'(LAT_ITOF);
      OP_SINE,
      OP_COSINE:       lat_o = LAT_W'(LAT_TRIG);
      default:         lat_o = LAT_W'(LAT_SHORT);
    endcase
  end
endmodule

// File: rtl/wbs_ring.sv
module wbs_ring #(
  parameter int DEPTH  = 7,
  parameter int DATA_W = 32,
  parameter int LAT_W  = 3,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SUM_W = $clog2(2 * DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic              ins_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_data_o,
  output logic              coll_o
);
  logic [PTR_W-1:0]  head_q;
  logic [PTR_W-1:0]  tgt;
  logic [SUM_W-1:0]  sum;
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  // tgt = (head + 1 + lat - 1) mod DEPTH, relative to the pre-advance head
  assign sum = SUM_W'(head_q) + SUM_W'(lat_i);
  assign tgt = (sum >= SUM_W'(DEPTH)) ? PTR_W'(sum - SUM_W'(DEPTH)) : PTR_W'(sum);

  assign head_data_o = slot_q[head_q];
  // the head slot is cleared this cycle, so a landing there is no collision
  assign coll_o = adv_i & ins_i & vld_q[tgt] & (tgt != head_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      vld_q  <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else if (adv_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_i && PTR_W'(i) == tgt) begin
          slot_q[i] <= data_i;
          vld_q[i]  <= 1'b1;
        end else if (PTR_W'(i) == head_q) begin
          slot_q[i] <= '0;
          vld_q[i]  <= 1'b0;
        end
      end
      head_q <= (head_q == PTR_W'(DEPTH - 1)) ? '0 : head_q + PTR_W'(1);
    end
  end
endmodule

// File: rtl/wbs_sat_cnt.sv
module wbs_sat_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/lat_wb_sched.sv
module lat_wb_sched #(
  parameter int DATA_W = 32,
  parameter int REG_AW = 7,
  parameter int OP_W   = 4,
  parameter int DEPTH  = wbs_pkg::MAX_LAT,
  parameter int CNT_W  = 16,
  localparam int LAT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [REG_AW-1:0] dest_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              step_o,
  output logic [CNT_W-1:0]  coll_cnt_o
);
  logic [LAT_W-1:0] lat;
  logic             op_ins;
  logic             op_adv;
  logic             adv;
  logic             coll;

  wbs_lat_lut #(.OP_W(OP_W), .LAT_W(LAT_W)) u_lut (
    .op_i  (opcode_i),
    .lat_o (lat),
    .ins_o (op_ins),
    .adv_o (op_adv)
  );

  assign adv = issue_i & op_adv;

  wbs_ring #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LAT_W(LAT_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (adv),
    .ins_i       (op_ins),
    .lat_i       (lat),
    .data_i      (result_i),
    .head_data_o (wr_data_o),
    .coll_o      (coll)
  );

  wbs_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (coll),
    .cnt_o  (coll_cnt_o)
  );

  assign wr_en_o   = adv & (|dest_i);
  assign wr_addr_o = dest_i;
  assign step_o    = adv;
endmodule

// File: rtl/wbs_chk.sv
module wbs_chk #(
  parameter int REG_AW = 7,
  parameter int OP_W   = 4,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic [OP_W-1:0]   opcode_i,
  input logic [REG_AW-1:0] dest_i,
  input logic              wr_en_o,
  input logic [REG_AW-1:0] wr_addr_o,
  input logic              step_o,
  input logic [CNT_W-1:0]  coll_cnt_o
);
  AST_DEST0_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_i || dest_i == '0) |-> !wr_en_o); // R4
  AST_VOUT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && opcode_i == OP_W'(7)) |-> (!step_o && !wr_en_o)); // R6
  AST_OTHER_STEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && opcode_i != OP_W'(7)) |-> step_o); // R6
  AST_ADDR_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o == dest_i)); // R10
  AST_IDLE_NO_COLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(coll_cnt_o)); // R8
  AST_NOP_NO_COLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && opcode_i == OP_W'(0)) |=> $stable(coll_cnt_o)); // R5
endmodule

bind lat_wb_sched wbs_chk #(.REG_AW(REG_AW), .OP_W(OP_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .issue_i    (issue_i),
  .opcode_i   (opcode_i),
  .dest_i     (dest_i),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .step_o     (step_o),
  .coll_cnt_o (coll_cnt_o)
);

// File: tb/lat_wb_sched_bench.sv
module lat_wb_sched_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        issue_i = 1'b0;
  logic [3:0]  opcode_i = '0;
  logic [6:0]  dest_i = '0;
  logic [31:0] result_i = '0;
  logic        wr_en_o;
  logic [6:0]  wr_addr_o;
  logic [31:0] wr_data_o;
  logic        step_o;
  logic [15:0] coll_cnt_o;

  always #4 clk_i = ~clk_i;

  lat_wb_sched u_lat_wb_sched (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] due [0:7];
  bit          dv  [0:7];
  int          exp_cnt = 0;
  logic [31:0] seed = 32'h1357_9bdf;

  function automatic int lat_of(logic [3:0] op);
    case (op)
      4'd1, 4'd2: return 5;
      4'd3:       return 7;
      4'd6:       return 3;
      4'd8, 4'd9: return 4;
      4'd0, 4'd7: return 0;
      default:    return 2;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < 8; k++) begin due[k] = '0; dv[k] = 1'b0; end
    exp_cnt = 0;
  endtask

  task automatic issue(logic [3:0] op, logic [6:0] d, logic [31:0] v, string tag);
    bit adv, en;
    int l;
    @(negedge clk_i);
    issue_i = 1'b1; opcode_i = op; dest_i = d; result_i = v;
    #2;
    adv = (op != 4'd7);
    en  = adv && (d != 0);
    chk(step_o == adv, tag, "step", 32'(step_o), 32'(adv));
    chk(wr_en_o == en, tag, "wr_en", 32'(wr_en_o), 32'(en));
    if (en) begin
      chk(wr_data_o == due[0], tag, "wr_data", wr_data_o, due[0]);
      chk(wr_addr_o == d, "R10", "wr_addr", 32'(wr_addr_o), 32'(d));
    end
    if (adv) begin
      for (int k = 0; k < 7; k++) begin due[k] = due[k+1]; dv[k] = dv[k+1]; end
      due[7] = '0; dv[7] = 1'b0;
      l = lat_of(op);
      if (l > 0) begin
        if (dv[l-1] && exp_cnt < 65535) exp_cnt++;
        due[l-1] = v; dv[l-1] = 1'b1;
      end
    end
    @(posedge clk_i); #1;
    chk(coll_cnt_o == 16'(exp_cnt), "R8", "coll_cnt", 32'(coll_cnt_o), 32'(exp_cnt));
  endtask

  task automatic idle();
    @(negedge clk_i);
    issue_i = 1'b0; opcode_i = 4'd3; dest_i = 7'd5; result_i = 32'hBAD0_BAD0;
    #2;
    chk(wr_en_o == 1'b0, "R4", "idle wr_en", 32'(wr_en_o), 32'd0);
    chk(step_o == 1'b0, "R6", "idle step", 32'(step_o), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_clear();
    #20;
    chk(wr_en_o == 1'b0, "R1", "reset wr_en", 32'(wr_en_o), 32'd0);
    chk(coll_cnt_o == 0, "R1", "reset count", 32'(coll_cnt_o), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;

    // R1: queued values are dropped by reset
    issue(4'd3, 7'd0, 32'h1111_0001, "R1");
    issue(4'd1, 7'd0, 32'h1111_0002, "R1");
    issue(4'd4, 7'd0, 32'h1111_0003, "R1");
    @(negedge clk_i); rst_ni = 1'b0; issue_i = 1'b0;
    model_clear();
    #2;
    chk(coll_cnt_o == 0, "R1", "count after reset", 32'(coll_cnt_o), 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < 8; i++) issue(4'd0, 7'd5, 32'hDEAD_0000, "R1");

    // R2: single long producer delivered on the 7th later issue
    issue(4'd3, 7'd0, 32'hC0DE_0007, "R2");
    for (int i = 0; i < 8; i++) issue(4'd0, 7'(12 + i), 32'h0, "R2");

    // R3: every latency class
    for (int op = 1; op < 16; op++) begin
      if (op == 7) continue;
      issue(4'(op), 7'd0, 32'hA000_0000 | 32'(op), "R3");
      for (int i = 0; i < 8; i++) issue(4'd0, 7'd9, 32'h0, "R3");
    end

    // R5: NOP values never surface
    issue(4'd1, 7'd0, 32'h5555_0001, "R5");
    for (int i = 0; i < 9; i++) issue(4'd0, 7'd33, 32'hDEAD_BEEF, "R5");

    // R6: vector outputs do not count toward latency
    issue(4'd6, 7'd0, 32'h6666_0003, "R6");
    for (int i = 0; i < 4; i++) begin
      issue(4'd7, 7'd40, 32'h0, "R6");
      issue(4'd0, 7'd41, 32'h0, "R6");
      idle();
    end

    // R8: later producer lands on pending slot
    issue(4'd1, 7'd0, 32'h8888_0001, "R8");
    issue(4'd8, 7'd0, 32'h8888_0002, "R8");
    issue(4'd3, 7'd0, 32'h8888_0003, "R8");
    issue(4'd6, 7'd0, 32'h8888_0004, "R8");
    // R9: everything drains, then only zeros follow
    for (int i = 0; i < 16; i++) issue(4'd0, 7'd77, 32'h0, "R9");

    // R7: pseudo-random sweep across wraps
    for (int i = 0; i < 3000; i++) begin
      seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
      if (seed[31:29] == 3'd0) idle();
      else issue(seed[3:0], (seed[6:4] == 3'd0) ? 7'd0 : seed[13:7], {seed[15:0], seed[31:16]}, "R7");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule